// File: doc/BRIEF.md
# FIFO Level Status and Interrupt Controller

This block sits beside the transmit and receive FIFOs of a serial port controller. It does not store FIFO data. It keeps one occupancy counter per FIFO and follows the push and pop strobes from the bus side and the serial-engine side. From those counts, and from a small set of programmable registers, it derives several outputs: the status flags, a five-bit raw interrupt vector, the masked vector, a single interrupt line, and one DMA request per direction.

Software programs the following through a plain register write and read port: the interrupt thresholds, the interrupt mask, the DMA enables and the DMA watermarks. The same port clears the sticky error bits and reads back the fill levels and interrupt state.

Two kinds of interrupt are produced. The level-type interrupts (transmit low, receive high) follow their comparison against a threshold on every cycle. The error-type interrupts (transmit overflow, receive underflow, receive overflow) latch when the error occurs and stay set until software clears them.

Top module: `xfi_top`

## Requirements
- R1: The transmit level rises by one on an accepted `tx_push` and falls by one on a `tx_pop` when the level is non-zero. A `tx_push` seen while the level equals DEPTH is dropped and leaves the level unchanged. A dropped push sets the sticky transmit-overflow bit (raw bit 1). A `tx_pop` at level zero is ignored.
- R2: An `rx_pop` at receive level zero leaves the level unchanged and sets the sticky receive-underflow bit (raw bit 2). A non-empty `rx_pop` decrements the level. An accepted `rx_push` increments it.
- R3: An `rx_push` seen while the receive level equals DEPTH is dropped and sets the sticky receive-overflow bit (raw bit 3). An `rx_pop` in the same cycle still decrements the level.
- R4: A write to the clear register (address 3) clears sticky bits. Data bit 1 clears underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow, and bit 0 clears all three. If an error occurs in the same cycle as its clear, the bit stays set.
- R5: Raw bit 0 is 1 whenever the transmit level is less than or equal to the transmit threshold (address 0).
- R6: Raw bit 4 is 1 whenever the receive level is strictly greater than the receive threshold (address 1).
- R7: The masked vector equals the raw vector ANDed with the 5-bit mask (address 2). `irq` is the OR of the masked bits.
- R8: The status vector has the following bits. Bit 0 is `engine_busy`. Bit 1 is transmit full (level equals DEPTH). Bit 2 is transmit empty. Bit 3 is receive empty. Bit 4 is receive full.
- R9: The DMA enable register (address 4) holds two bits, bit 0 for receive and bit 1 for transmit. `tx_dma_req` is 1 when transmit DMA is enabled and the transmit level is less than or equal to the transmit watermark (address 5). `rx_dma_req` is 1 when receive DMA is enabled and the receive level is greater than the receive watermark (address 6).
- R10: After reset, all registers and levels are zero. Reading an address returns the value of that register, zero-extended. The register widths are: thresholds and watermarks LVL_W bits, mask 5 bits, DMA enable 2 bits. Address 7 reads the transmit level, 8 the receive level, 9 the raw vector, 10 the masked vector and 11 the status vector. Address 3 and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Bus writes one transmit entry |
| tx_pop | input | 1 | Serial engine takes one transmit entry |
| rx_push | input | 1 | Serial engine delivers one receive entry |
| rx_pop | input | 1 | Bus reads one receive entry |
| engine_busy | input | 1 | Serial engine is shifting |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_addr` |
| tx_level | output | LVL_W | Transmit occupancy |
| rx_level | output | LVL_W | Receive occupancy |
| status | output | 5 | Status flags |
| raw_irq | output | 5 | Unmasked interrupt vector |
| masked_irq | output | 5 | Masked interrupt vector |
| irq | output | 1 | Interrupt line |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Two kinds of same-cycle collision are the focus. The first is a sticky error firing in the same cycle as a software clear of that bit. The second is a dropped push on a full FIFO coinciding with a pop from the other side. The bench drives an overflow push and a clear write on the same edge, with the clear given both as the per-bit code and as the clear-all code. It also drives `rx_push` with `rx_pop` at full, and `rx_pop` with `rx_push` at empty. A behavioural model with integer levels predicts the result of each collision. The level, raw, masked, status, DMA and readback outputs are compared against the model after every clock.

// File: rtl/xfi_pkg.sv
package xfi_pkg;
  localparam logic [3:0] A_TX_THR = 4'd0;
  localparam logic [3:0] A_RX_THR = 4'd1;
  localparam logic [3:0] A_MASK   = 4'd2;
  localparam logic [3:0] A_CLEAR  = 4'd3;
  localparam logic [3:0] A_DMA_EN = 4'd4;
  localparam logic [3:0] A_TX_WM  = 4'd5;
  localparam logic [3:0] A_RX_WM  = 4'd6;
  localparam logic [3:0] A_TX_LVL = 4'd7;
  localparam logic [3:0] A_RX_LVL = 4'd8;
  localparam logic [3:0] A_RAW    = 4'd9;
  localparam logic [3:0] A_MSKD   = 4'd10;
  localparam logic [3:0] A_STAT   = 4'd11;

  // sticky error slot indices
  localparam int E_TX_OVF = 0;
  localparam int E_RX_UNF = 1;
  localparam int E_RX_OVF = 2;
  localparam int N_ERR    = 3;

  // level at or below a limit (low-water style)
  function automatic logic lvl_at_or_below(input logic [15:0] lvl, input logic [15:0] lim);
    return lvl <= lim;
  endfunction

  // level strictly above a limit (high-water style)
  function automatic logic lvl_above(input logic [15:0] lvl, input logic [15:0] lim);
    return lvl > lim;
  endfunction

  // expand a clear-register write into per-error clear strobes
  function automatic logic [N_ERR-1:0] clear_decode(input logic [3:0] c);
    logic [N_ERR-1:0] r;
    r[E_TX_OVF] = c[0] | c[3];
    r[E_RX_UNF] = c[0] | c[1];
    r[E_RX_OVF] = c[0] | c[2];
    return r;
  endfunction
endpackage

// File: rtl/xfi_level_counter.sv
module xfi_level_counter #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             drop,
  output logic             starve
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

  logic inc, dec;

  assign full   = (level == TOP);
  assign empty  = (level == '0);
  assign drop   = push & full;
  assign starve = pop & empty;
  assign inc    = push & ~full;
  assign dec    = pop & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          level <= '0;
    else if (inc && !dec) level <= level + 1'b1;
    else if (dec && !inc) level <= level - 1'b1;
  end

  // R1 / R3: occupancy never exceeds the depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);
  // R1 / R3: a dropped push with no pop leaves the level alone
  a_r3_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> $stable(level));
  // R2: an empty pop with no push leaves the level alone
  a_r2_starve_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (starve && !push) |=> $stable(level));
  // R1: an accepted lone push raises the level by one
  a_r1_push_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/xfi_sticky_err.sv
module xfi_sticky_err #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[gi] <= 1'b0;
      else if (set[gi]) q[gi] <= 1'b1;
      else if (clr[gi]) q[gi] <= 1'b0;
    end

    // R4: a new error wins over a clear in the same cycle
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[gi] |=> q[gi]);
    // R4: a clear without a new error empties the bit
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[gi] && !set[gi]) |=> !q[gi]);
    // R4: with neither, the bit holds
    a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[gi] && !clr[gi]) |=> $stable(q[gi]));
  end
endmodule

// File: rtl/xfi_cfg_regs.sv
module xfi_cfg_regs
  import xfi_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [LVL_W-1:0] tx_thr,
  output logic [LVL_W-1:0] rx_thr,
  output logic [4:0]       mask,
  output logic [1:0]       dma_en,
  output logic [LVL_W-1:0] tx_wm,
  output logic [LVL_W-1:0] rx_wm,
  output logic [N_ERR-1:0] err_clr
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign err_clr = (we && addr == A_CLEAR) ? clear_decode(wdata[3:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
      mask   <= '0;
      dma_en <= '0;
      tx_wm  <= '0;
      rx_wm  <= '0;
    end else if (we) begin
      case (addr)
        A_TX_THR: tx_thr <= wdata[LVL_W-1:0];
        A_RX_THR: rx_thr <= wdata[LVL_W-1:0];
        A_MASK:   mask   <= wdata[4:0];
        A_DMA_EN: dma_en <= wdata[1:0];
        A_TX_WM:  tx_wm  <= wdata[LVL_W-1:0];
        A_RX_WM:  rx_wm  <= wdata[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  // R10: a write elsewhere never changes the mask
  a_r10_mask_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_MASK) |=> $stable(mask));
endmodule

// File: rtl/xfi_top.sv
module xfi_top
  import xfi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             engine_busy,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level,
  output logic [4:0]       status,
  output logic [4:0]       raw_irq,
  output logic [4:0]       masked_irq,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  // named internal events
  logic tx_full, tx_empty, tx_drop, tx_starve;
  logic rx_full, rx_empty, rx_drop, rx_starve;
  logic [LVL_W-1:0] tx_thr, rx_thr, tx_wm, rx_wm;
  logic [4:0]       mask;
  logic [1:0]       dma_en;
  logic [N_ERR-1:0] err_set, err_clr, err_q;
  logic             tx_low_hit, rx_high_hit;
  logic             unused_tx_starve;

  assign unused_tx_starve = tx_starve;

  xfi_level_counter #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_txc (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .drop(tx_drop), .starve(tx_starve));

  xfi_level_counter #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxc (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .drop(rx_drop), .starve(rx_starve));

  xfi_cfg_regs #(.LVL_W(LVL_W), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask), .dma_en(dma_en),
    .tx_wm(tx_wm), .rx_wm(rx_wm), .err_clr(err_clr));

  always_comb begin
    err_set           = '0;
    err_set[E_TX_OVF] = tx_drop;
    err_set[E_RX_UNF] = rx_starve;
    err_set[E_RX_OVF] = rx_drop;
  end

  xfi_sticky_err #(.N(N_ERR)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .q(err_q));

  assign tx_low_hit  = lvl_at_or_below(16'(tx_level), 16'(tx_thr));
  assign rx_high_hit = lvl_above(16'(rx_level), 16'(rx_thr));

  assign raw_irq    = {rx_high_hit, err_q[E_RX_OVF], err_q[E_RX_UNF],
                       err_q[E_TX_OVF], tx_low_hit};
  assign masked_irq = raw_irq & mask;
  assign irq        = |masked_irq;
  assign status     = {rx_full, rx_empty, tx_empty, tx_full, engine_busy};

  assign tx_dma_req = dma_en[1] & lvl_at_or_below(16'(tx_level), 16'(tx_wm));
  assign rx_dma_req = dma_en[0] & lvl_above(16'(rx_level), 16'(rx_wm));

  always_comb begin
    case (reg_addr)
      A_TX_THR: reg_rdata = REG_W'(tx_thr);
      A_RX_THR: reg_rdata = REG_W'(rx_thr);
      A_MASK:   reg_rdata = REG_W'(mask);
      A_DMA_EN: reg_rdata = REG_W'(dma_en);
      A_TX_WM:  reg_rdata = REG_W'(tx_wm);
      A_RX_WM:  reg_rdata = REG_W'(rx_wm);
      A_TX_LVL: reg_rdata = REG_W'(tx_level);
      A_RX_LVL: reg_rdata = REG_W'(rx_level);
      A_RAW:    reg_rdata = REG_W'(raw_irq);
      A_MSKD:   reg_rdata = REG_W'(masked_irq);
      A_STAT:   reg_rdata = REG_W'(status);
      default:  reg_rdata = '0;
    endcase
  end

  // R7: no bit passes the mask that the mask does not allow
  a_r7_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_irq & ~mask) == 5'b0);
  // R7: the line follows the masked vector
  a_r7_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (masked_irq != 5'b0));
  // R9: disabled channels never request
  a_r9_tx_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en[1] |-> !tx_dma_req);
  a_r9_rx_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en[0] |-> !rx_dma_req);
  // R8: a FIFO is never full and empty at once
  a_r8_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]) && !(status[3] && status[4]));
  // R1: a dropped transmit push leaves the overflow bit set next cycle
  a_r1_tx_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> raw_irq[1]);
endmodule

// File: tb/sim_xfi_top.sv
module sim_xfi_top;
  localparam int CLK_P = 10;
  localparam int D     = 16;
  localparam int LW    = 5;
  localparam int RW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, engine_busy = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [RW-1:0] reg_wdata = 0;
  logic [RW-1:0] reg_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic [4:0] status, raw_irq, masked_irq;
  logic irq, tx_dma_req, rx_dma_req;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_txl = 0, m_rxl = 0, m_tthr = 0, m_rthr = 0, m_mask = 0, m_en = 0, m_twm = 0, m_rwm = 0;
  bit m_tovf = 0, m_runf = 0, m_rovf = 0;

  always #(CLK_P/2) clk = ~clk;

  xfi_top #(.DEPTH(D)) u0 (
    .clk, .rst_n, .tx_push, .tx_pop, .rx_push, .rx_pop, .engine_busy,
    .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .tx_level, .rx_level,
    .status, .raw_irq, .masked_irq, .irq, .tx_dma_req, .rx_dma_req);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_raw();
    return ((m_rxl > m_rthr) << 4) | (m_rovf << 3) | (m_runf << 2) | (m_tovf << 1) | (m_txl <= m_tthr);
  endfunction

  function automatic int exp_stat();
    return ((m_rxl == D) << 4) | ((m_rxl == 0) << 3) | ((m_txl == 0) << 2) | ((m_txl == D) << 1) | int'(engine_busy);
  endfunction

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_tthr;  1: return m_rthr;  2: return m_mask;  4: return m_en;
      5: return m_twm;   6: return m_rwm;   7: return m_txl;   8: return m_rxl;
      9: return exp_raw(); 10: return exp_raw() & m_mask; 11: return exp_stat();
      default: return 0;
    endcase
  endfunction

  // advance the model with the inputs held across the edge
  task automatic model_step();
    bit td = tx_push && m_txl == D;
    bit tp = tx_pop && m_txl > 0;
    bit rd = rx_push && m_rxl == D;
    bit ru = rx_pop && m_rxl == 0;
    bit rp = rx_pop && m_rxl > 0;
    int w = int'(reg_wdata);
    bit c_t = 0, c_u = 0, c_o = 0;
    if (reg_we && reg_addr == 3) begin
      c_t = w[0] | w[3]; c_u = w[0] | w[1]; c_o = w[0] | w[2];
    end
    m_txl = m_txl + int'(tx_push && !td) - int'(tp);
    m_rxl = m_rxl + int'(rx_push && !rd) - int'(rp);
    m_tovf = td | (m_tovf & !c_t);
    m_runf = ru | (m_runf & !c_u);
    m_rovf = rd | (m_rovf & !c_o);
    if (reg_we) case (reg_addr)
      0: m_tthr = w & 31;  1: m_rthr = w & 31;  2: m_mask = w & 31;
      4: m_en = w & 3;     5: m_twm = w & 31;   6: m_rwm = w & 31;
      default: ;
    endcase
  endtask

  task automatic compare_all();
    int r = exp_raw();
    chk("R1", "tx_level", int'(tx_level), m_txl);
    chk("R2", "rx_level", int'(rx_level), m_rxl);
    chk("R4", "sticky raw[3:1]", int'(raw_irq[3:1]), (r >> 1) & 7);
    chk("R5", "raw[0]", int'(raw_irq[0]), r & 1);
    chk("R6", "raw[4]", int'(raw_irq[4]), (r >> 4) & 1);
    chk("R7", "masked", int'(masked_irq), r & m_mask);
    chk("R7", "irq", int'(irq), int'((r & m_mask) != 0));
    chk("R8", "status", int'(status), exp_stat());
    chk("R9", "tx_dma_req", int'(tx_dma_req), int'(m_en[1] && m_txl <= m_twm));
    chk("R9", "rx_dma_req", int'(rx_dma_req), int'(m_en[0] && m_rxl > m_rwm));
    chk("R10", "reg_rdata", int'(reg_rdata), exp_rd(int'(reg_addr)));
  endtask

  // one clock: inputs already set at negedge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_io(input bit tpu, tpo, rpu, rpo, we, input int a, input int d);
    tx_push = tpu; tx_pop = tpo; rx_push = rpu; rx_pop = rpo;
    reg_we = we; reg_addr = 4'(a); reg_wdata = RW'(d);
  endtask

  task automatic wr(input int a, input int d);
    set_io(0, 0, 0, 0, 1, a, d); cyc(); set_io(0, 0, 0, 0, 0, a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all();                         // R10 reset state
    chk("R10", "reset raw", int'(raw_irq), 1);

    // R1: fill tx past full, overflow sticks
    for (int i = 0; i < D + 3; i++) begin set_io(1, 0, 0, 0, 0, 7, 0); cyc(); end
    // R4: overflow push together with its clear -> stays set
    set_io(1, 0, 0, 0, 1, 3, 8); cyc();
    chk("R4", "set beats clear", int'(raw_irq[1]), 1);
    set_io(0, 0, 0, 0, 1, 3, 8); cyc();
    chk("R4", "per-bit clear", int'(raw_irq[1]), 0);
    // R3: fill rx, then push with pop at full
    for (int i = 0; i < D; i++) begin set_io(0, 0, 1, 0, 0, 8, 0); cyc(); end
    set_io(0, 0, 1, 1, 0, 8, 0); cyc();
    chk("R3", "push+pop at full level", int'(rx_level), D - 1);
    // R2: drain rx, then pop with push at empty
    for (int i = 0; i < D + 1; i++) begin set_io(0, 0, 0, 1, 0, 9, 0); cyc(); end
    set_io(0, 0, 1, 1, 0, 9, 0); cyc();
    chk("R2", "pop+push at empty level", int'(rx_level), 1);
    // R4: clear-all with a new underflow on another bit
    set_io(0, 0, 0, 1, 0, 9, 0); cyc();
    set_io(0, 0, 0, 1, 1, 3, 1); cyc();
    chk("R4", "clear-all vs new underflow", int'(raw_irq[3:1]), 3'b010);
    wr(3, 1);
    chk("R4", "clear-all", int'(raw_irq[3:1]), 0);
    // R7 / R9: open the mask and DMA
    wr(2, 31); wr(4, 3); wr(5, 4); wr(6, 2); wr(0, 8); wr(1, 3);

    // randomized phases with push/pop bias
    for (int p = 0; p < 40; p++) begin
      for (int k = 0; k < 150; k++) begin
        bit hi = p[0];
        engine_busy = $urandom_range(0, 1) != 0;
        set_io(($urandom_range(0, 9) < (hi ? 8 : 2)), ($urandom_range(0, 9) < (hi ? 2 : 8)),
               ($urandom_range(0, 9) < (hi ? 8 : 2)), ($urandom_range(0, 9) < (hi ? 2 : 8)),
               ($urandom_range(0, 7) == 0), $urandom_range(0, 13), $urandom_range(0, 255));
        cyc();
      end
    end
    set_io(0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule